// File: doc/BRIEF.md
# Timebase Reference-Compare Interrupt Unit

The block keeps a free-running 64-bit timebase and watches its low 32-bit word against two programmable 32-bit reference values. The counter steps by one on each pulse of a tick-enable input, but only while counting is enabled in the control word and no debug freeze is holding it. When a step lands the low word on a reference value, a sticky match flag for that reference sets. The flag stays set until software writes a 1 to it.

All state sits behind a 16-bit register bus with a write strobe and a combinational read path. A single 16-bit control/status word holds an eight-bit one-hot interrupt level field, the two match flags, a per-reference interrupt enable, a freeze-honour control and a count enable. Any flag whose enable is on drives exactly one of eight interrupt level lines: the lowest-numbered level whose bit is set in the level field. The interrupt controller that consumes these lines is outside the block.

Top module: `tbcmp_unit`

## Requirements
- R1: After reset the control word reads 0x0000, both reference registers and all four counter halfwords read 0, and every interrupt line is low.
- R2: With the count enable (control bit 0) set, the counter rises by exactly one at each clock edge where `tick` is high. It holds when `tick` is low or the count enable is clear.
- R3: With the freeze control (control bit 1) set, the counter holds while `dbg_freeze` is high. With the freeze control clear, `dbg_freeze` has no effect.
- R4: The counter is 64 bits wide, and a step carries from the low word into the high word. Its halfwords are read and written at byte offsets 0x10 (bits 63:48), 0x12, 0x14 and 0x16 (bits 15:0). A counter write in a cycle replaces the step for that cycle.
- R5: Reference A sits at 0x04 (upper half) and 0x06 (lower half), and reference B at 0x08 and 0x0A. Both read back what was written. The control word sits at 0x00.
- R6: Match flag A (control bit 7) sets at the clock edge where a step brings the counter's low 32 bits equal to reference A. Flag B (control bit 6) does the same for reference B. The high word of the counter plays no part in the compare.
- R7: A match flag stays set until a control write carries a 1 in its bit position. A 0 there leaves it unchanged, and one write can clear both flags.
- R8: If a match sets a flag in the same cycle that a write clears it, the flag stays set.
- R9: Control bits 15:8 hold the interrupt level field, bit 3 enables interrupts from flag A, bit 2 does the same for flag B, and bits 1 and 0 are as in R2 and R3. These bits read back as written. Bits 5:4 always read 0 and ignore writes.
- R10: Level n maps to control bit 15-n and to `irq_lvl[n]`. While (flag A and enable A) or (flag B and enable B) holds, the line for the lowest-numbered level set in the field is high and all other lines are low. With nothing pending, or with an empty level field, all lines are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count pulse, one step per high cycle |
| dbg_freeze | input | 1 | Debug freeze request |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte address of a halfword register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_lvl | output | 8 | Interrupt level lines, at most one high |

## Verification
The bench parks the counter just below each reference value and steps it across the match. A design that compared the whole 64-bit value, or that compared the value before the step, would raise the flag one step late or never. It writes zeros and then ones to the flag bits: a design that treated them as plain read/write bits would lose flags on a zero write. It writes a clear in the very cycle a match arrives, where a clear-priority design drops the flag. It sets two level bits at once and level 7 alone, which exposes a reversed level field or a highest-first priority choice. It also forces a low-word carry and sets the reserved bits, which catch a 32-bit counter and writable reserved bits.

// File: rtl/tbcmp_pkg.sv
// Package: shared constants and the control-register type of the timebase
// compare unit. Bit positions are fixed by the register layout that
// software decodes; addresses are byte offsets of 16-bit halfwords.
package tbcmp_pkg;
    localparam int HW_W       = 16;   // bus / halfword width
    localparam int LEVELS     = 8;    // interrupt level lines
    localparam int NUM_REF    = 2;    // reference channels (A, B)
    localparam int ADDR_CTRL  = 0;    // control/status word
    localparam int ADDR_REF0  = 4;    // reference A, upper half
    localparam int REF_STRIDE = 4;    // bytes between reference channels
    localparam int ADDR_CNT   = 16;   // counter bits 63:48
    localparam int BIT_PRIO0  = 15;   // level 0 bit; level n at 15-n
    localparam int BIT_HIT0   = 7;    // flag A; flag B at 6
    localparam int BIT_IEN0   = 3;    // enable A; enable B at 2
    localparam int BIT_FRZ    = 1;    // honour debug freeze
    localparam int BIT_RUN    = 0;    // count enable

    typedef struct packed {
        logic [LEVELS-1:0]  prio;     // index = level number
        logic [NUM_REF-1:0] ien;      // index = channel
        logic               frz;
        logic               run;
    } ctrl_t;
endpackage

// File: rtl/tbcmp_counter.sv
// Module: 64-bit timebase counter with per-halfword load.
// Steps by one when `adv` is high; a halfword load in the same cycle wins
// over the step. Exposes the low word of the next value so that compare
// logic can flag a match on the edge where the counter takes it.
// Assumes CNT_W is a multiple of HW_W and LO_W <= CNT_W.
module tbcmp_counter #(
    parameter int CNT_W = 64,
    parameter int HW_W  = 16,
    parameter int LO_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adv,
    input  logic [CNT_W/HW_W-1:0]   hw_we,
    input  logic [HW_W-1:0]         wdata,
    output logic [CNT_W-1:0]        cnt,
    output logic [LO_W-1:0]         cnt_lo_nxt,
    output logic                    stepped
);
    localparam int NHW = CNT_W / HW_W;

    logic [CNT_W-1:0] cnt_nxt;

    // Next-value selection: halfword load, else step, else hold.
    always_comb begin
        cnt_nxt = cnt;
        stepped = 1'b0;
        if (|hw_we) begin
            for (int j = 0; j < NHW; j++) begin
                if (hw_we[j]) cnt_nxt[j*HW_W +: HW_W] = wdata;
            end
        end else if (adv) begin
            cnt_nxt = cnt + CNT_W'(1);
            stepped = 1'b1;
        end
    end

    assign cnt_lo_nxt = cnt_nxt[LO_W-1:0];

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nxt;
    end

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !(|hw_we)) |=> (cnt == $past(cnt) + CNT_W'(1)));   // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !(|hw_we)) |=> $stable(cnt));                      // R2
endmodule

// File: rtl/tbcmp_ref_chan.sv
// Module: one reference-compare channel.
// Holds a reference value written as halfwords and a sticky match flag.
// The flag sets when the counter steps onto the reference low word; a
// write-one clear in the same cycle loses to the set.
// Assumes REF_W is a multiple of HW_W.
module tbcmp_ref_chan #(
    parameter int REF_W = 32,
    parameter int HW_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [REF_W/HW_W-1:0]   hw_we,
    input  logic [HW_W-1:0]         wdata,
    input  logic                    stepped,
    input  logic [REF_W-1:0]        cnt_lo_nxt,
    input  logic                    clr,
    output logic [REF_W-1:0]        ref_val,
    output logic                    hit
);
    localparam int NHW = REF_W / HW_W;

    logic hit_set;

    assign hit_set = stepped && (cnt_lo_nxt == ref_val);

    // Reference register, loaded one halfword at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_val <= '0;
        end else begin
            for (int j = 0; j < NHW; j++) begin
                if (hw_we[j]) ref_val[j*HW_W +: HW_W] <= wdata;
            end
        end
    end

    // Sticky match flag: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       hit <= 1'b0;
        else if (hit_set) hit <= 1'b1;
        else if (clr)     hit <= 1'b0;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !clr) |=> hit);                                     // R7
    AST_FLAG_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit) |-> $past(stepped));                             // R6
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && stepped && (cnt_lo_nxt == ref_val)) |=> hit);       // R8
endmodule

// File: rtl/tbcmp_irq_steer.sv
// Module: interrupt level steering.
// Drives the single line of the lowest-numbered level set in the level
// field while any enabled flag is pending. Purely combinational.
module tbcmp_irq_steer #(
    parameter int LEVELS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEVELS-1:0] prio,
    input  logic              pending,
    output logic [LEVELS-1:0] irq
);
    logic [LEVELS-1:0] lowest;

    // Isolate the lowest set level bit.
    always_comb begin
        lowest = '0;
        for (int i = LEVELS - 1; i >= 0; i--) begin
            if (prio[i]) lowest = LEVELS'(1) << i;
        end
    end

    assign irq = pending ? lowest : '0;

    AST_IRQ_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq));                                             // R10
    AST_IRQ_IN_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & ~prio) == '0));                                     // R10
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq) |-> pending);                                        // R10
endmodule

// File: rtl/tbcmp_unit.sv
// Module: timebase reference-compare interrupt unit (top).
// A 64-bit tick-driven timebase, two 32-bit reference-compare channels
// with sticky write-one-to-clear flags, a control word and a one-hot
// interrupt level output, all behind a 16-bit halfword register bus.
// Assumes halfword-aligned byte addresses; unmapped reads return 0.
module tbcmp_unit
    import tbcmp_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int REF_W  = 32,
    parameter int ADDR_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                dbg_freeze,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [HW_W-1:0]     bus_wdata,
    output logic [HW_W-1:0]     bus_rdata,
    output logic [LEVELS-1:0]   irq_lvl
);
    localparam int CNT_HW = CNT_W / HW_W;
    localparam int REF_HW = REF_W / HW_W;

    ctrl_t                          ctrl_q;
    logic                           ctrl_we;
    logic                           adv;
    logic [CNT_HW-1:0]              cnt_we;
    logic [CNT_W-1:0]               cnt;
    logic [REF_W-1:0]               cnt_lo_nxt;
    logic                           stepped;
    logic [NUM_REF-1:0]             hit;
    logic [NUM_REF-1:0]             pend_src;
    logic [NUM_REF-1:0][REF_W-1:0]  ref_val;
    logic [HW_W-1:0]                ctrl_word;

    assign ctrl_we = bus_we && (bus_addr == ADDR_W'(ADDR_CTRL));
    assign adv     = tick && ctrl_q.run && !(ctrl_q.frz && dbg_freeze);

    // Counter halfword write decode: upper halfword at the lowest address.
    for (genvar j = 0; j < CNT_HW; j++) begin : g_cnt_we
        assign cnt_we[j] = bus_we &&
            (bus_addr == ADDR_W'(ADDR_CNT + 2 * (CNT_HW - 1 - j)));
    end

    tbcmp_counter #(
        .CNT_W (CNT_W),
        .HW_W  (HW_W),
        .LO_W  (REF_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (adv),
        .hw_we      (cnt_we),
        .wdata      (bus_wdata),
        .cnt        (cnt),
        .cnt_lo_nxt (cnt_lo_nxt),
        .stepped    (stepped)
    );

    // One compare channel per reference register.
    for (genvar c = 0; c < NUM_REF; c++) begin : g_ch
        logic [REF_HW-1:0] ref_we;
        for (genvar j = 0; j < REF_HW; j++) begin : g_we
            assign ref_we[j] = bus_we && (bus_addr ==
                ADDR_W'(ADDR_REF0 + REF_STRIDE * c + 2 * (REF_HW - 1 - j)));
        end
        tbcmp_ref_chan #(
            .REF_W (REF_W),
            .HW_W  (HW_W)
        ) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .hw_we      (ref_we),
            .wdata      (bus_wdata),
            .stepped    (stepped),
            .cnt_lo_nxt (cnt_lo_nxt),
            .clr        (ctrl_we && bus_wdata[BIT_HIT0 - c]),
            .ref_val    (ref_val[c]),
            .hit        (hit[c])
        );
        assign pend_src[c] = hit[c] && ctrl_q.ien[c];
    end

    // Control register: plain read/write fields; flags live in channels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            for (int i = 0; i < LEVELS; i++) ctrl_q.prio[i] <= bus_wdata[BIT_PRIO0 - i];
            for (int c = 0; c < NUM_REF; c++) ctrl_q.ien[c] <= bus_wdata[BIT_IEN0 - c];
            ctrl_q.frz <= bus_wdata[BIT_FRZ];
            ctrl_q.run <= bus_wdata[BIT_RUN];
        end
    end

    // Control word as seen on a read; reserved bits stay 0.
    always_comb begin
        ctrl_word = '0;
        for (int i = 0; i < LEVELS; i++) ctrl_word[BIT_PRIO0 - i] = ctrl_q.prio[i];
        for (int c = 0; c < NUM_REF; c++) begin
            ctrl_word[BIT_HIT0 - c] = hit[c];
            ctrl_word[BIT_IEN0 - c] = ctrl_q.ien[c];
        end
        ctrl_word[BIT_FRZ] = ctrl_q.frz;
        ctrl_word[BIT_RUN] = ctrl_q.run;
    end

    // Read multiplexer over all mapped halfwords.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(ADDR_CTRL)) bus_rdata = ctrl_word;
        for (int c = 0; c < NUM_REF; c++) begin
            for (int j = 0; j < REF_HW; j++) begin
                if (bus_addr == ADDR_W'(ADDR_REF0 + REF_STRIDE * c + 2 * (REF_HW - 1 - j)))
                    bus_rdata = ref_val[c][j*HW_W +: HW_W];
            end
        end
        for (int j = 0; j < CNT_HW; j++) begin
            if (bus_addr == ADDR_W'(ADDR_CNT + 2 * (CNT_HW - 1 - j)))
                bus_rdata = cnt[j*HW_W +: HW_W];
        end
    end

    tbcmp_irq_steer #(
        .LEVELS (LEVELS)
    ) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .prio    (ctrl_q.prio),
        .pending (|pend_src),
        .irq     (irq_lvl)
    );

    AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.frz && dbg_freeze && !(|cnt_we)) |=> $stable(cnt)); // R3
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(ADDR_CTRL)) |-> (bus_rdata[5:4] == 2'b00)); // R9
    AST_NO_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.run && !(|cnt_we)) |=> $stable(cnt));              // R2
endmodule

// File: tb/sim_tbcmp_unit.sv
// Directed bench for tbcmp_unit: one task per scenario, each checking
// its own results at the ports.
module sim_tbcmp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        dbg_freeze = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  irq_lvl;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    tbcmp_unit u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .dbg_freeze (dbg_freeze),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_lvl    (irq_lvl)
    );

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wr_tick(logic [4:0] a, logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; tick = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tick = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd_cnt(output logic [63:0] v);
        logic [15:0] h;
        for (int j = 0; j < 4; j++) begin
            rd(5'(16 + 2 * j), h);
            v[63 - 16*j -: 16] = h;
        end
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic t_reset();
        logic [15:0] d; logic [63:0] c;
        rd(5'h00, d); chk("R1 ctrl", 64'(d), 64'h0000);
        rd(5'h04, d); chk("R1 refA hi", 64'(d), 64'h0);
        rd(5'h0A, d); chk("R1 refB lo", 64'(d), 64'h0);
        rd_cnt(c);    chk("R1 counter", c, 64'h0);
        chk("R1 irq", 64'(irq_lvl), 64'h0);
    endtask

    task automatic t_count();
        logic [63:0] c;
        wr(5'h00, 16'h0001);
        ticks(5);
        rd_cnt(c); chk("R2 five ticks", c, 64'd5);
        repeat (3) @(negedge clk);
        rd_cnt(c); chk("R2 no tick holds", c, 64'd5);
        wr(5'h00, 16'h0000);
        ticks(3);
        rd_cnt(c); chk("R2 disabled holds", c, 64'd5);
    endtask

    task automatic t_freeze();
        logic [63:0] c;
        wr(5'h00, 16'h0003);
        dbg_freeze = 1'b1;
        ticks(4);
        rd_cnt(c); chk("R3 frozen", c, 64'd5);
        wr(5'h00, 16'h0001);
        ticks(2);
        rd_cnt(c); chk("R3 freeze ignored", c, 64'd7);
        dbg_freeze = 1'b0;
    endtask

    task automatic t_refs();
        logic [15:0] d;
        wr(5'h04, 16'h1234); wr(5'h06, 16'h5678);
        wr(5'h08, 16'h0000); wr(5'h0A, 16'h0020);
        rd(5'h04, d); chk("R5 refA hi", 64'(d), 64'h1234);
        rd(5'h06, d); chk("R5 refA lo", 64'(d), 64'h5678);
        rd(5'h0A, d); chk("R5 refB lo", 64'(d), 64'h0020);
    endtask

    task automatic t_carry();
        logic [63:0] c;
        wr(5'h10, 16'h0000); wr(5'h12, 16'h0001);
        wr(5'h14, 16'hFFFF); wr(5'h16, 16'hFFFE);
        rd_cnt(c); chk("R4 load", c, 64'h0000_0001_FFFF_FFFE);
        ticks(2);
        rd_cnt(c); chk("R4 carry", c, 64'h0000_0002_0000_0000);
    endtask

    task automatic t_match();
        logic [15:0] d;
        wr(5'h14, 16'h0000); wr(5'h16, 16'h001E);
        ticks(1);
        rd(5'h00, d); chk("R6 no early B", 64'(d), 64'h0001);
        ticks(1);
        rd(5'h00, d); chk("R6 B on match, low word only", 64'(d), 64'h0041);
        ticks(1);
        rd(5'h00, d); chk("R7 B sticky", 64'(d), 64'h0041);
        wr(5'h14, 16'h1234); wr(5'h16, 16'h5677);
        ticks(1);
        rd(5'h00, d); chk("R6 A on match", 64'(d), 64'h00C1);
    endtask

    task automatic t_w1c();
        logic [15:0] d;
        wr(5'h00, 16'h0001);
        rd(5'h00, d); chk("R7 zero write keeps", 64'(d), 64'h00C1);
        wr(5'h00, 16'h00C1);
        rd(5'h00, d); chk("R7 both cleared", 64'(d), 64'h0001);
    endtask

    task automatic t_irq();
        logic [15:0] d;
        wr(5'h14, 16'h0000); wr(5'h16, 16'h001F);
        ticks(1);
        wr(5'h00, 16'h2405);
        rd(5'h00, d); chk("R9 ctrl readback", 64'(d), 64'h2445);
        chk("R10 lowest level 2", 64'(irq_lvl), 64'h04);
        wr(5'h00, 16'h0105);
        #1 chk("R10 level 7", 64'(irq_lvl), 64'h80);
        wr(5'h00, 16'h2409);
        #1 chk("R10 A enabled, A clear", 64'(irq_lvl), 64'h00);
        wr(5'h00, 16'h0005);
        #1 chk("R10 empty field", 64'(irq_lvl), 64'h00);
    endtask

    task automatic t_collide();
        logic [15:0] d;
        wr(5'h00, 16'h0041);
        rd(5'h00, d); chk("R7 clear B", 64'(d), 64'h0001);
        wr(5'h14, 16'h0000); wr(5'h16, 16'h001F);
        wr_tick(5'h00, 16'h0041);
        rd(5'h00, d); chk("R8 set beats clear", 64'(d), 64'h0041);
    endtask

    task automatic t_reserved();
        logic [15:0] d;
        wr(5'h00, 16'h0031);
        rd(5'h00, d); chk("R9 reserved ignore", 64'(d), 64'h0041);
        wr(5'h00, 16'hA50F);
        rd(5'h00, d); chk("R9 layout", 64'(d), 64'hA54F);
    endtask

    initial begin
        #(8 * 100000);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count();
        t_freeze();
        t_refs();
        t_carry();
        t_match();
        t_w1c();
        t_irq();
        t_collide();
        t_reserved();
        finish_run();
    end
endmodule